// File: doc/BRIEF.md
# Byte-Wide NAND Flash Command Front End

This block is the device-side front end of a byte-wide NAND memory. It watches an 8-bit input bus and takes a byte on each rising edge of the active-low write strobe. The two latch-enable lines tell it whether the byte is a command, an address or a data byte. Address bytes build a column and a row address. Data bytes fill a 264-byte page register through a column pointer. Each falling edge of the active-low read strobe shifts one byte out of that register and moves the pointer on. The front end checks the order of commands and runs page load, page program, block erase and reset. Each of these holds a ready/busy output low for a fixed number of clock cycles.

A small behavioural cell array sits behind the page register. It has `2**ROW_BITS` rows, and each group of 16 rows forms one erase block. The pointer works in one of two regions: main bytes 0..255, or spare bytes 256..263. It stops at the last byte and returns that byte again on every later strobe. All strobe pins are sampled with the block clock.

Top module: `nand_cmd_if`

## Requirements
- R1: A byte counts only on a rising edge of `weN` with `ceN` low. `cle`=1 with `ale`=0 makes it a command, `ale`=1 with `cle`=0 makes it an address, and both low makes it data. With `ceN` high, write-strobe bytes and read-strobe edges are ignored.
- R2: Address bytes land in this order. The first is the column. The second is row bits 7:0. The third gives row bits 12:8 from its bits 4:0. Any further address byte has no effect. The array row is row bits `ROW_BITS-1:0`, and the erase block is row bits `ROW_BITS-1:4`.
- R3: Command 00h selects the main region, where the pointer equals the column. Command 50h selects the spare region, where the pointer is 256 plus column bits 2:0. The spare region stays selected through later commands until 00h is accepted.
- R4: After 00h or 50h, the third address byte starts a page load. `readyBusy` is low for exactly `LOAD_CYC` cycles, starting the cycle after that edge. The page register then holds the addressed row.
- R5: In read-out, each `reN` falling edge puts the byte at the pointer on `ioOut` and then advances the pointer. At byte 263 the pointer holds, so byte 263 repeats.
- R6: The sequence 80h, then address bytes, then data bytes writes the data bytes into the page register at successive pointer positions. A following 10h holds busy for `PROG_CYC` cycles and then stores the page register into the addressed row.
- R7: After 80h, any command other than 10h or FFh abandons the pending program. No store takes place and `badCmd` is set. The rejected command is not executed, and a later 10h starts nothing.
- R8: The sequence 60h, two row-address bytes, then D0h holds busy for `ERASE_CYC` cycles. It then sets every row of the addressed block to FFh. A D0h that does not follow such a setup is dropped and sets `badCmd`.
- R9: FFh clears the address registers to zero, fills the page register with FFh and busies for `RST_CYC` cycles. It also cancels a program, erase or load that is in progress. An FFh that arrives while a reset is still busy does not lengthen it.
- R10: 90h followed by one address byte enters identifier read-out. The read strobes then return 98h, then 64h, and 64h on every later strobe.
- R11: A command byte outside {00,10,50,60,80,90,D0,FF}h is dropped and leaves the operating state unchanged. It sets `badCmd`, which stays set until `rstN`.
- R12: While `readyBusy` is low, every bus cycle and read strobe is ignored, except an FFh that cancels a non-reset operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Active-low chip select |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| weN | input | 1 | Active-low write strobe, byte taken on its rise |
| reN | input | 1 | Active-low read strobe, byte shifted out on its fall |
| ioIn | input | 8 | Command, address and data byte input |
| ioOut | output | 8 | Read-out byte |
| readyBusy | output | 1 | 1 = ready, 0 = busy |
| badCmd | output | 1 | Sticky flag for a rejected command |

## Verification
The assertions assume that `weN` and `reN` each stay at a level for at least one clock. This lets every edge be seen once by the one-cycle-delayed copy. They also assume that `cle`, `ale` and `ioIn` hold steady from the falling edge of `weN` through the clock that sees it rise. The bench drives all pins on the falling clock edge and holds each strobe level for one full clock. Random data and column values come from a seeded `$urandom`, so every pattern stays inside these limits.

// File: rtl/nand_if_pkg.sv
package nand_if_pkg;

  localparam logic [7:0] CMD_READ_MAIN   = 8'h00;
  localparam logic [7:0] CMD_READ_SPARE  = 8'h50;
  localparam logic [7:0] CMD_LOAD_DATA   = 8'h80;
  localparam logic [7:0] CMD_PROGRAM     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_IDENT       = 8'h90;
  localparam logic [7:0] CMD_RESET       = 8'hFF;

  typedef enum logic [2:0] {
    M_IDLE, M_RD_ADDR, M_RD_OUT, M_PG_DATA, M_ER_ADDR, M_ID_ADDR, M_ID_OUT
  } mode_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_PROG, OP_ERASE, OP_RST
  } op_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic       addrWe;
    logic [1:0] addrIdx;
    logic       dataWe;
    logic       rdStep;
    logic       idStep;
    logic       idClear;
    logic       setMain;
    logic       setSpare;
    logic       doLoad;
    logic       doStore;
    logic       doErase;
    logic       doReset;
  } strobe_t;

endpackage

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
  import nand_if_pkg::*;
#(
  parameter int LOAD_CYC  = 12,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40,
  parameter int RST_CYC   = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic [7:0] ioIn,
  output logic       readyBusy,
  output logic       badCmd,
  output strobe_t    st
);

  localparam int MAX_A = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int MAX_B = (ERASE_CYC > RST_CYC) ? ERASE_CYC : RST_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             weD, reD;
  mode_t            mode, modeN;
  op_t              busyOp, opN;
  logic [CNT_W-1:0] busyCnt, cntN;
  logic [1:0]       addrCnt, addrCntN;
  logic             badN;

  wire weRise = weN & ~weD;
  wire reFall = ~reN & reD;
  wire cmdCyc  = weRise & ~ceN & cle & ~ale;
  wire addrCyc = weRise & ~ceN & ale & ~cle;
  wire dataCyc = weRise & ~ceN & ~cle & ~ale;
  wire busy    = (busyCnt != '0);
  wire finish  = (busyCnt == CNT_W'(1));
  wire addrMode = (mode == M_RD_ADDR) || (mode == M_PG_DATA) ||
                  (mode == M_ER_ADDR) || (mode == M_ID_ADDR);

  always_comb begin
    st       = '0;
    modeN    = mode;
    opN      = busyOp;
    cntN     = busyCnt;
    addrCntN = addrCnt;
    badN     = badCmd;
    if (busy) begin
      cntN = busyCnt - 1'b1;
      if (finish) begin
        opN   = OP_NONE;
        modeN = M_IDLE;
        case (busyOp)
          OP_LOAD:  begin st.doLoad = 1'b1; modeN = M_RD_OUT; end
          OP_PROG:  st.doStore = 1'b1;
          OP_ERASE: st.doErase = 1'b1;
          default:  ;
        endcase
      end
      if (cmdCyc && ioIn == CMD_RESET && busyOp != OP_RST) begin
        st         = '0;
        st.doReset = 1'b1;
        modeN      = M_IDLE;
        opN        = OP_RST;
        cntN       = CNT_W'(RST_CYC);
      end
    end else if (cmdCyc) begin
      if (mode == M_PG_DATA && ioIn != CMD_PROGRAM && ioIn != CMD_RESET) begin
        modeN = M_IDLE;
        badN  = 1'b1;
      end else begin
        case (ioIn)
          CMD_READ_MAIN:  begin modeN = M_RD_ADDR; addrCntN = 2'd0; st.setMain = 1'b1; end
          CMD_READ_SPARE: begin modeN = M_RD_ADDR; addrCntN = 2'd0; st.setSpare = 1'b1; end
          CMD_LOAD_DATA:  begin modeN = M_PG_DATA; addrCntN = 2'd0; end
          CMD_PROGRAM:
            if (mode == M_PG_DATA) begin
              modeN = M_IDLE; opN = OP_PROG; cntN = CNT_W'(PROG_CYC);
            end else badN = 1'b1;
          CMD_ERASE_SETUP: begin modeN = M_ER_ADDR; addrCntN = 2'd1; end
          CMD_ERASE_GO:
            if (mode == M_ER_ADDR && addrCnt == 2'd3) begin
              modeN = M_IDLE; opN = OP_ERASE; cntN = CNT_W'(ERASE_CYC);
            end else badN = 1'b1;
          CMD_IDENT: begin modeN = M_ID_ADDR; st.idClear = 1'b1; end
          CMD_RESET: begin
            st.doReset = 1'b1; modeN = M_IDLE; opN = OP_RST; cntN = CNT_W'(RST_CYC);
          end
          default: badN = 1'b1;
        endcase
      end
    end else if (addrCyc && addrMode) begin
      if (mode == M_ID_ADDR) modeN = M_ID_OUT;
      else if (addrCnt != 2'd3) begin
        st.addrWe  = 1'b1;
        st.addrIdx = addrCnt;
        addrCntN   = addrCnt + 2'd1;
        if (mode == M_RD_ADDR && addrCnt == 2'd2) begin
          opN  = OP_LOAD;
          cntN = CNT_W'(LOAD_CYC);
        end
      end
    end else if (dataCyc && mode == M_PG_DATA) begin
      st.dataWe = 1'b1;
    end else if (reFall && !ceN) begin
      st.rdStep = (mode == M_RD_OUT);
      st.idStep = (mode == M_ID_OUT);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weD     <= 1'b1;
      reD     <= 1'b1;
      mode    <= M_IDLE;
      busyOp  <= OP_NONE;
      busyCnt <= '0;
      addrCnt <= 2'd0;
      badCmd  <= 1'b0;
    end else begin
      weD     <= weN;
      reD     <= reN;
      mode    <= modeN;
      busyOp  <= opN;
      busyCnt <= cntN;
      addrCnt <= addrCntN;
      badCmd  <= badN;
    end
  end

  assign readyBusy = ~busy;

  // R4: busy only ever begins on a write-strobe rise
  a_r4_busy_from_we: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyBusy) |-> $past(weRise));
  // R11: rejection flag never clears while out of reset
  a_r11_bad_sticky: assert property (@(posedge clk) disable iff (!rstN)
    badCmd |=> badCmd);
  // R9: a reset in progress counts straight down, never restarted
  a_r9_rst_not_extended: assert property (@(posedge clk) disable iff (!rstN)
    (busyOp == OP_RST && busy) |=> busyCnt == $past(busyCnt) - 1'b1);

endmodule

// File: rtl/nand_page_dpath.sv
module nand_page_dpath
  import nand_if_pkg::*;
#(
  parameter int         PAGE_BYTES = 264,
  parameter int         MAIN_BYTES = 256,
  parameter int         ROW_BITS   = 5,
  parameter int         PG_BITS    = 4,
  parameter logic [7:0] MAKER_CODE = 8'h98,
  parameter logic [7:0] DEV_CODE   = 8'h64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioIn,
  input  strobe_t    st,
  output logic [7:0] ioOut
);

  localparam int PTR_W    = $clog2(PAGE_BYTES);
  localparam int PAGE_W   = PAGE_BYTES * 8;
  localparam int NUM_ROWS = 1 << ROW_BITS;
  localparam int ROW_W    = 13;
  localparam int SPARE_W  = $clog2(PAGE_BYTES - MAIN_BYTES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PAGE_BYTES - 1);

  logic [7:0]        colReg;
  logic [ROW_W-1:0]  rowReg;
  logic              spare;
  logic [PTR_W-1:0]  ptr;
  logic [PAGE_W-1:0] pageReg;
  logic              idIdx;
  logic [PAGE_W-1:0] arrayMem [NUM_ROWS];

  wire [ROW_BITS-1:0] rowIdx = rowReg[ROW_BITS-1:0];

  function automatic logic [PTR_W-1:0] colToPtr(input logic inSpare, input logic [7:0] col);
    return inSpare ? PTR_W'(MAIN_BYTES) + PTR_W'(col[SPARE_W-1:0]) : PTR_W'(col);
  endfunction

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? LAST : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colReg  <= '0;
      rowReg  <= '0;
      spare   <= 1'b0;
      ptr     <= '0;
      pageReg <= '1;
      idIdx   <= 1'b0;
      ioOut   <= '0;
    end else if (st.doReset) begin
      colReg  <= '0;
      rowReg  <= '0;
      pageReg <= '1;
      ptr     <= colToPtr(spare, 8'h00);
      idIdx   <= 1'b0;
    end else begin
      if (st.setMain) begin
        spare <= 1'b0;
        ptr   <= colToPtr(1'b0, colReg);
      end
      if (st.setSpare) begin
        spare <= 1'b1;
        ptr   <= colToPtr(1'b1, colReg);
      end
      if (st.addrWe) begin
        case (st.addrIdx)
          2'd0:    begin colReg <= ioIn; ptr <= colToPtr(spare, ioIn); end
          2'd1:    rowReg[7:0] <= ioIn;
          default: rowReg[ROW_W-1:8] <= ioIn[ROW_W-9:0];
        endcase
      end
      if (st.dataWe) begin
        pageReg[{ptr, 3'b000} +: 8] <= ioIn;
        ptr <= stepPtr(ptr);
      end
      if (st.rdStep) begin
        ioOut <= pageReg[{ptr, 3'b000} +: 8];
        ptr   <= stepPtr(ptr);
      end
      if (st.idClear) idIdx <= 1'b0;
      if (st.idStep) begin
        ioOut <= idIdx ? DEV_CODE : MAKER_CODE;
        idIdx <= 1'b1;
      end
      if (st.doLoad) pageReg <= arrayMem[rowIdx];
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    localparam logic [ROW_BITS-1:0] RIDX = ROW_BITS'(r);
    wire inBlock = (rowReg[ROW_BITS-1:PG_BITS] == RIDX[ROW_BITS-1:PG_BITS]);
    always_ff @(posedge clk) begin
      if (st.doStore && rowIdx == RIDX) arrayMem[r] <= pageReg;
      else if (st.doErase && inBlock)   arrayMem[r] <= '1;
    end
  end

  // R5: pointer never leaves the page
  a_r5_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST);
  // R5: at the final byte a read strobe leaves the pointer parked
  a_r5_hold_last: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdStep && !st.doReset && ptr == LAST) |=> ptr == LAST);
  // R3: in the spare region the pointer stays in the spare bytes
  a_r3_spare_region: assert property (@(posedge clk) disable iff (!rstN)
    spare |-> ptr >= PTR_W'(MAIN_BYTES));
  // R9: reset leaves the page register all ones
  a_r9_page_ones: assert property (@(posedge clk) disable iff (!rstN)
    st.doReset |=> pageReg == '1);

endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
  import nand_if_pkg::*;
#(
  parameter int LOAD_CYC  = 12,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40,
  parameter int RST_CYC   = 6,
  parameter int ROW_BITS  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       readyBusy,
  output logic       badCmd
);

  strobe_t st;

  nand_cmd_ctrl #(
    .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .ioIn(ioIn),
    .readyBusy(readyBusy), .badCmd(badCmd), .st(st)
  );

  nand_page_dpath #(
    .PAGE_BYTES(264), .MAIN_BYTES(256), .ROW_BITS(ROW_BITS), .PG_BITS(4),
    .MAKER_CODE(8'h98), .DEV_CODE(8'h64)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .st(st), .ioOut(ioOut)
  );

endmodule

// File: tb/tb_nand_cmd_if.sv
`timescale 1ns/1ps
module tb_nand_cmd_if;

  localparam int LOAD  = 12;
  localparam int PROG  = 20;
  localparam int ERASE = 40;
  localparam int RST   = 6;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b0, cle = 1'b0, ale = 1'b0;
  logic weN = 1'b1, reN = 1'b1;
  logic [7:0] ioIn = '0;
  logic [7:0] ioOut;
  logic readyBusy, badCmd;

  int tests = 0, fails = 0;
  bit done = 0;
  byte unsigned mem [512][264];

  always #4 clk = ~clk;

  nand_cmd_if #(.LOAD_CYC(LOAD), .PROG_CYC(PROG), .ERASE_CYC(ERASE),
                .RST_CYC(RST), .ROW_BITS(9)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
    .reN(reN), .ioIn(ioIn), .ioOut(ioOut), .readyBusy(readyBusy), .badCmd(badCmd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int satIdx(input int p);
    return (p > 263) ? 263 : p;
  endfunction

  task automatic busCycle(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; ioIn = d; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
  endtask
  task automatic cmd(input logic [7:0] d); busCycle(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d); busCycle(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d); busCycle(1'b0, 1'b0, d); endtask
  task automatic settle; @(negedge clk); endtask

  task automatic waitBusy(output int n);
    n = 0;
    @(negedge clk);
    while (!readyBusy) begin n++; @(negedge clk); end
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk); reN = 1'b0;
    @(negedge clk); b = ioOut; reN = 1'b1;
  endtask

  task automatic pulseReset;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic rowAddr(input int row);
    adr(row[7:0]); adr({3'b000, row[12:8]});
  endtask

  task automatic openRead(input logic [7:0] c, input logic [7:0] col, input int row, input string tag);
    int n;
    cmd(c); adr(col); rowAddr(row);
    waitBusy(n);
    chk(tag, n, LOAD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] b;
    int rows [6] = '{0, 5, 10, 15, 19, 261};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    chk("R4 reset ready", readyBusy, 1);
    chk("R11 reset flag clear", badCmd, 0);

    // R6 / R2: program six rows, one with a fourth address byte, one using cycle 3
    foreach (rows[i]) begin
      cmd(8'h80); adr(8'h00); rowAddr(rows[i]);
      if (rows[i] == 5) adr(8'hA5);
      for (int k = 0; k < 264; k++) begin
        mem[rows[i]][k] = 8'($urandom);
        dat(mem[rows[i]][k]);
      end
      cmd(8'h10);
      waitBusy(n);
      chk("R6 program busy length", n, PROG);
    end

    // R4 / R2: read back every row from a random column
    foreach (rows[i]) begin
      automatic int col = $urandom % 256;
      openRead(8'h00, col[7:0], rows[i], "R4 load busy length");
      for (int k = 0; k < 6; k++) begin
        rd(b);
        chk("R2 R5 read data", b, mem[rows[i]][col + k]);
      end
    end

    // R5: run past the end of the page
    openRead(8'h00, 8'd250, 0, "R4 load busy length");
    for (int k = 0; k < 20; k++) begin
      rd(b);
      chk("R5 saturating read", b, mem[0][satIdx(250 + k)]);
    end

    // R3: spare region read, then spare persists into a program
    openRead(8'h50, 8'hFD, 5, "R4 load busy length spare");
    for (int k = 0; k < 5; k++) begin
      rd(b);
      chk("R3 spare read", b, mem[5][satIdx(261 + k)]);
    end
    cmd(8'h80); adr(8'h02); rowAddr(10); dat(8'hAA); dat(8'hBB); cmd(8'h10);
    waitBusy(n);
    for (int k = 0; k < 264; k++) mem[10][k] = mem[5][k];
    mem[10][258] = 8'hAA; mem[10][259] = 8'hBB;
    openRead(8'h00, 8'hFF, 10, "R4 load busy length");
    for (int k = 0; k < 6; k++) begin
      rd(b);
      chk("R3 main region after 00h", b, mem[10][255 + k]);
    end

    // R10: identifier read-out
    cmd(8'h90); adr(8'h00);
    rd(b); chk("R10 maker code", b, 8'h98);
    rd(b); chk("R10 device code", b, 8'h64);
    rd(b); chk("R10 device code repeats", b, 8'h64);
    chk("R10 no busy", readyBusy, 1);

    // R7: program abandoned by a foreign command
    cmd(8'h80); adr(8'h00); rowAddr(15); dat(8'hEE); cmd(8'h00);
    settle();
    chk("R7 flag after foreign cmd", badCmd, 1);
    chk("R7 no busy", readyBusy, 1);
    cmd(8'h10); settle();
    chk("R7 late 10h starts nothing", readyBusy, 1);
    pulseReset();
    settle();
    chk("R11 flag cleared by rstN", badCmd, 0);
    openRead(8'h00, 8'h00, 15, "R4 load busy length");
    rd(b); chk("R7 row not stored", b, mem[15][0]);

    // R8: lone D0h rejected, then a proper block erase
    cmd(8'hD0); settle();
    chk("R8 lone D0 flagged", badCmd, 1);
    chk("R8 lone D0 no busy", readyBusy, 1);
    pulseReset();
    cmd(8'h60); adr(8'h13); adr(8'h00); cmd(8'hD0);
    waitBusy(n);
    chk("R8 erase busy length", n, ERASE);
    for (int r = 16; r < 32; r++) for (int k = 0; k < 264; k++) mem[r][k] = 8'hFF;
    openRead(8'h00, 8'h00, 19, "R4 load busy length");
    for (int k = 0; k < 4; k++) begin
      rd(b); chk("R8 erased row", b, 8'hFF);
    end
    openRead(8'h00, 8'h00, 15, "R4 load busy length");
    rd(b); chk("R8 other block kept", b, mem[15][0]);

    // R12 / R1: bytes during busy and with chip deselected are ignored
    cmd(8'h00); adr(8'h00); rowAddr(0);
    cmd(8'h3C); adr(8'h40);
    waitBusy(n);
    chk("R12 busy not disturbed", n, LOAD - 4);
    chk("R12 cmd during busy ignored", badCmd, 0);
    ceN = 1'b1;
    cmd(8'h3C);
    rd(b);
    ceN = 1'b0;
    settle();
    chk("R1 deselected cmd ignored", badCmd, 0);
    rd(b); chk("R1 R12 first byte from col 0", b, mem[0][0]);

    // R11: unlisted command mid read-out
    openRead(8'h00, 8'd10, 0, "R4 load busy length");
    rd(b); rd(b);
    cmd(8'h3C); settle();
    chk("R11 unlisted flagged", badCmd, 1);
    rd(b); chk("R11 read-out continues", b, mem[0][12]);

    // R9: reset clears address and fills the page register
    cmd(8'hFF); waitBusy(n);
    chk("R9 reset busy length", n, RST);
    cmd(8'h80); dat(8'h77); cmd(8'h10); waitBusy(n);
    mem[0][0] = 8'h77;
    for (int k = 1; k < 264; k++) mem[0][k] = 8'hFF;
    openRead(8'h00, 8'h00, 0, "R4 load busy length");
    rd(b); chk("R9 zero address, data at col 0", b, 8'h77);
    rd(b); chk("R9 page ones", b, 8'hFF);
    rd(b); chk("R9 page ones", b, 8'hFF);

    // R9: second FFh during reset does not extend it
    cmd(8'hFF); cmd(8'hFF); waitBusy(n);
    chk("R9 repeated reset ignored", n, RST - 2);

    // R9: reset cancels a program in flight
    cmd(8'h80); adr(8'h00); rowAddr(15); dat(8'h01); cmd(8'h10); cmd(8'hFF);
    waitBusy(n);
    chk("R9 reset busy replaces program", n, RST);
    openRead(8'h00, 8'h00, 15, "R4 load busy length");
    rd(b); chk("R9 cancelled program not stored", b, mem[15][0]);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule